// File: doc/BRIEF.md
# Destination-keyed predicate register map

This block holds a small table that tells instruction decode, for any destination register, whether an operation writing it is predicated and which register holds the predicate bitfield. Software fills the table through a word-wide write port and can read any entry back. Each entry binds one destination register of one register class (integer or floating-point) to one predicate source register, and carries an enable bit.

Decode does not search the table. After every table write the block rescans all entries and rebuilds two per-register lookup arrays, one per register class, each giving an enable flag and a predicate register index for every one of the 32 registers. A decode query then costs one array read. The query result is registered and appears one clock after the query is presented.

Top module: `dest_pred_map`

## Requirements
- R1: An entry word has the enable bit at bit 11, the class bit at bit 10 (0 = integer, 1 = floating-point), the destination register index at bits 9:5 and the predicate register index at bits 4:0; a write stores the word in the addressed entry, and the read port returns the entry addressed by `rd_addr` one clock later.
- R2: Reset clears every entry to zero and empties both lookup arrays, so all reads return 0 and all queries miss.
- R3: A query for destination D of class C, presented when an enabled entry of class C names destination D, returns `lk_hit` = 1 and that entry's predicate index on `lk_pred` one clock later.
- R4: An entry only affects queries of its own class: an integer entry never hits a floating-point query for the same index, and the reverse.
- R5: An entry whose enable bit is 0 contributes nothing; writing an entry with its enable bit cleared removes the mapping it previously supplied.
- R6: When several enabled entries name the same destination and class, the one with the highest entry number supplies the predicate index.
- R7: A table write affects queries presented two or more clocks after the write cycle; queries presented in the write cycle or in the cycle right after it return the mapping from before the write.
- R8: A read presented in the same cycle as a write to the same entry returns the entry's old contents.
- R9: When a query misses, `lk_pred` is 0.
- R10: Rewriting an entry with a different destination moves its mapping: the old destination no longer hits through that entry and the new one does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | 4 | Entry number to write |
| wr_data | input | 12 | Packed entry word |
| rd_addr | input | 4 | Entry number to read |
| rd_data | output | 12 | Registered entry word |
| lk_dest | input | 5 | Destination register index to look up |
| lk_is_fp | input | 1 | Class of the queried register (1 = floating-point) |
| lk_hit | output | 1 | Registered: destination is predicated |
| lk_pred | output | 5 | Registered: predicate register index, 0 on a miss |

## Verification
The assertions check on every cycle that a write lands in the addressed entry, that a colliding read returns the old word, that the lookup arrays stay frozen unless a rebuild is pending, and that a miss drives a zero predicate index. Class separation, the priority of higher entries, removal by clearing the enable bit, moving a mapping and the exact two-clock visibility window of a write are shown only by the bench's directed and random scenarios against its reference model.

// File: rtl/pred_map_pkg.sv
package pred_map_pkg;

  // Register index width for both register classes.
  parameter int unsigned PM_REG_IDX_W = 5;
  // Number of registers per class.
  parameter int unsigned PM_NUM_REGS  = 1 << PM_REG_IDX_W;

  // Entry word: enable, class, destination index, predicate index (MSB first).
  typedef struct packed {
    logic                    en;
    logic                    is_fp;
    logic [PM_REG_IDX_W-1:0] dst;
    logic [PM_REG_IDX_W-1:0] src;
  } pm_entry_t;

  parameter int unsigned PM_ENTRY_W = $bits(pm_entry_t);

  // Class selectors used as array indices.
  parameter int unsigned PM_CLS_INT = 0;
  parameter int unsigned PM_CLS_FP  = 1;
  parameter int unsigned PM_NUM_CLS = 2;

endpackage

// File: rtl/pred_entry_store.sv
module pred_entry_store
  import pred_map_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 16,
  localparam int unsigned AW = $clog2(N_ENTRIES)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en_i,
  input  logic [AW-1:0]   wr_addr_i,
  input  pm_entry_t       wr_data_i,
  input  logic [AW-1:0]   rd_addr_i,
  output pm_entry_t       rd_data_o,
  output pm_entry_t       entries_o [N_ENTRIES]
);

  pm_entry_t mem_q [N_ENTRIES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_ENTRIES; i++) mem_q[i] <= '0;
      rd_data_o <= '0;
    end else begin
      if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
      rd_data_o <= mem_q[rd_addr_i];
    end
  end

  always_comb begin
    for (int i = 0; i < N_ENTRIES; i++) entries_o[i] = mem_q[i];
  end

  // R1: a write is stored in the addressed entry.
  p_write_lands_r1: assert property (@(posedge clk) disable iff (rst)
    wr_en_i |=> (mem_q[$past(wr_addr_i)] == $past(wr_data_i)));

  // R8: a read colliding with a write returns the old word.
  p_read_old_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && (rd_addr_i == wr_addr_i)) |=> (rd_data_o == $past(mem_q[rd_addr_i])));

endmodule

// File: rtl/pred_scan.sv
module pred_scan
  import pred_map_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 16
) (
  input  pm_entry_t entries_i [N_ENTRIES],
  output logic [PM_NUM_CLS-1:0][PM_NUM_REGS-1:0]                   hit_o,
  output logic [PM_NUM_CLS-1:0][PM_NUM_REGS-1:0][PM_REG_IDX_W-1:0] src_o
);

  // One inversion network per register class.
  for (genvar c = 0; c < PM_NUM_CLS; c++) begin : g_cls
    always_comb begin
      for (int r = 0; r < PM_NUM_REGS; r++) begin
        hit_o[c][r] = 1'b0;
        src_o[c][r] = '0;
        // Ascending scan: a later match overrides, so the highest entry wins.
        for (int e = 0; e < N_ENTRIES; e++) begin
          if (entries_i[e].en && (entries_i[e].is_fp == 1'(c)) &&
              (entries_i[e].dst == PM_REG_IDX_W'(r))) begin
            hit_o[c][r] = 1'b1;
            src_o[c][r] = entries_i[e].src;
          end
        end
      end
    end
  end

endmodule

// File: rtl/pred_lookup_arrays.sv
module pred_lookup_arrays
  import pred_map_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic rebuild_i,
  input  logic [PM_NUM_CLS-1:0][PM_NUM_REGS-1:0]                   hit_i,
  input  logic [PM_NUM_CLS-1:0][PM_NUM_REGS-1:0][PM_REG_IDX_W-1:0] src_i,
  input  logic [PM_REG_IDX_W-1:0] lk_dest_i,
  input  logic                    lk_fp_i,
  output logic                    lk_hit_o,
  output logic [PM_REG_IDX_W-1:0] lk_src_o
);

  logic [PM_NUM_CLS-1:0][PM_NUM_REGS-1:0]                   en_q;
  logic [PM_NUM_CLS-1:0][PM_NUM_REGS-1:0][PM_REG_IDX_W-1:0] src_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      src_q <= '0;
    end else if (rebuild_i) begin
      en_q  <= hit_i;
      src_q <= src_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_hit_o <= 1'b0;
      lk_src_o <= '0;
    end else begin
      lk_hit_o <= en_q[lk_fp_i][lk_dest_i];
      lk_src_o <= src_q[lk_fp_i][lk_dest_i];
    end
  end

  // R5/R7: arrays change only on a pending rebuild.
  p_arrays_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !rebuild_i |=> ($stable(en_q) && $stable(src_q)));

  // R9: a miss carries a zero predicate index.
  p_miss_zero_r9: assert property (@(posedge clk) disable iff (rst)
    !lk_hit_o |-> (lk_src_o == '0));

endmodule

// File: rtl/dest_pred_map.sv
module dest_pred_map
  import pred_map_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 16,
  localparam int unsigned AW = $clog2(N_ENTRIES),
  localparam int unsigned EW = PM_ENTRY_W,
  localparam int unsigned RW = PM_REG_IDX_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [EW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [EW-1:0] rd_data,
  input  logic [RW-1:0] lk_dest,
  input  logic          lk_is_fp,
  output logic          lk_hit,
  output logic [RW-1:0] lk_pred
);

  pm_entry_t wr_entry;
  pm_entry_t rd_entry;
  pm_entry_t entries [N_ENTRIES];
  logic      rebuild_q;

  logic [PM_NUM_CLS-1:0][PM_NUM_REGS-1:0]         scan_hit;
  logic [PM_NUM_CLS-1:0][PM_NUM_REGS-1:0][RW-1:0] scan_src;

  assign wr_entry = pm_entry_t'(wr_data);
  assign rd_data  = EW'(rd_entry);

  // A rebuild is pending in the cycle after any write.
  always_ff @(posedge clk) begin
    if (rst) rebuild_q <= 1'b0;
    else     rebuild_q <= wr_en;
  end

  pred_entry_store #(.N_ENTRIES(N_ENTRIES)) u_store (
    .clk       (clk),
    .rst       (rst),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_entry),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_entry),
    .entries_o (entries)
  );

  pred_scan #(.N_ENTRIES(N_ENTRIES)) u_scan (
    .entries_i (entries),
    .hit_o     (scan_hit),
    .src_o     (scan_src)
  );

  pred_lookup_arrays u_arrays (
    .clk       (clk),
    .rst       (rst),
    .rebuild_i (rebuild_q),
    .hit_i     (scan_hit),
    .src_i     (scan_src),
    .lk_dest_i (lk_dest),
    .lk_fp_i   (lk_is_fp),
    .lk_hit_o  (lk_hit),
    .lk_src_o  (lk_pred)
  );

endmodule

// File: tb/dest_pred_map_bench.sv
module dest_pred_map_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [11:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [11:0] rd_data;
  logic [4:0]  lk_dest = '0;
  logic        lk_is_fp = 1'b0;
  logic        lk_hit;
  logic [4:0]  lk_pred;

  always #2 clk = ~clk;  // 250 MHz

  dest_pred_map u_dest_pred_map (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .lk_dest(lk_dest), .lk_is_fp(lk_is_fp),
    .lk_hit(lk_hit), .lk_pred(lk_pred)
  );

  int    vectors = 0;
  int    miscompares = 0;
  int    cycles = 0;
  bit    armed = 0;
  string tag = "R2 reset";

  // Reference model: table now, and as it stood one edge earlier.
  logic [11:0] tab_cur [16];
  logic [11:0] tab_p1  [16];
  logic        exp_hit;
  logic [4:0]  exp_pred;
  logic [11:0] exp_rd;

  function automatic logic [11:0] mk(input bit en, input bit fp, input int dst, input int src);
    return {en, fp, 5'(dst), 5'(src)};
  endfunction

  always @(posedge clk) begin
    cycles++;
    armed = 1;
    if (rst) begin
      foreach (tab_cur[i]) begin tab_cur[i] = '0; tab_p1[i] = '0; end
      exp_hit = 0; exp_pred = 0; exp_rd = 0;
    end else begin
      exp_hit = 0; exp_pred = 0;
      for (int e = 0; e < 16; e++)
        if (tab_p1[e][11] && tab_p1[e][10] == lk_is_fp && tab_p1[e][9:5] == lk_dest) begin
          exp_hit = 1; exp_pred = tab_p1[e][4:0];
        end
      exp_rd = tab_cur[rd_addr];
      tab_p1 = tab_cur;
      if (wr_en) tab_cur[wr_addr] = wr_data;
    end
  end

  always @(negedge clk) begin
    if (armed) begin
      vectors++;
      if (lk_hit !== exp_hit || lk_pred !== exp_pred) begin
        miscompares++;
        $display("FAIL %s lookup: got hit=%0b pred=%0d expected hit=%0b pred=%0d",
                 tag, lk_hit, lk_pred, exp_hit, exp_pred);
      end
      vectors++;
      if (rd_data !== exp_rd) begin
        miscompares++;
        $display("FAIL %s read: got %h expected %h", tag, rd_data, exp_rd);
      end
    end
  end

  always @(posedge clk) begin
    if (cycles > 150000) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic cyc(input bit we, input int wa, input logic [11:0] wd,
                     input int ra, input int dst, input bit fp);
    @(posedge clk); #1;
    wr_en = we; wr_addr = 4'(wa); wr_data = wd;
    rd_addr = 4'(ra); lk_dest = 5'(dst); lk_is_fp = fp;
  endtask

  task automatic wr(input int wa, input logic [11:0] wd, input int dst, input bit fp);
    cyc(1, wa, wd, wa, dst, fp);
  endtask

  task automatic idle(input int n, input int ra, input int dst, input bit fp);
    for (int i = 0; i < n; i++) cyc(0, 0, '0, ra, dst, fp);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    tag = "R2 reset";
    for (int i = 0; i < 16; i++) idle(1, i, 2 * i, i[0]);

    tag = "R3 int map";
    wr(0, mk(1, 0, 5, 7), 5, 0);
    idle(3, 0, 5, 0);
    tag = "R4 class split";
    idle(2, 0, 5, 1);
    wr(1, mk(1, 1, 5, 9), 5, 1);
    idle(3, 1, 5, 1);
    idle(2, 1, 5, 0);
    tag = "R6 higher wins";
    wr(3, mk(1, 0, 5, 12), 5, 0);
    idle(3, 3, 5, 0);
    wr(2, mk(1, 0, 5, 20), 5, 0);
    idle(3, 2, 5, 0);
    tag = "R5 disable removes";
    wr(3, mk(0, 0, 5, 12), 5, 0);
    idle(3, 3, 5, 0);
    wr(2, mk(0, 0, 5, 20), 5, 0);
    wr(0, mk(0, 0, 5, 7), 5, 0);
    idle(3, 0, 5, 0);
    tag = "R7 write visibility";
    wr(4, mk(1, 0, 8, 3), 8, 0);
    cyc(0, 0, '0, 4, 8, 0);
    cyc(0, 0, '0, 4, 8, 0);
    cyc(0, 0, '0, 4, 8, 0);
    tag = "R8 read during write";
    cyc(1, 4, mk(1, 0, 8, 31), 4, 8, 0);
    idle(3, 4, 8, 0);
    tag = "R10 move mapping";
    wr(4, mk(1, 0, 9, 31), 8, 0);
    idle(3, 4, 8, 0);
    idle(3, 4, 9, 0);
    tag = "R9 miss zero";
    idle(3, 5, 30, 1);
    tag = "R1 word layout";
    wr(15, mk(1, 1, 31, 17), 31, 1);
    idle(3, 15, 31, 1);

    tag = "R3 R6 random";
    for (int i = 0; i < 2000; i++)
      cyc(($urandom % 3) == 0, $urandom % 16,
          mk(($urandom % 4) != 0, $urandom % 2, $urandom % 6, $urandom % 32),
          $urandom % 16, $urandom % 6, $urandom % 2);
    idle(3, 0, 0, 0);

    tag = "R2 reset again";
    @(posedge clk); #1 rst = 1;
    idle(2, 0, 0, 0);
    #0 rst = 0;
    for (int i = 0; i < 6; i++) idle(1, i, i, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule